// File: doc/BRIEF.md
# Fractional Clock Divider with Noise Shaping

This block derives a divided clock from one of several source strobes that all live in one system clock domain. Each source is a clock-enable pulse, and one pulse is one source cycle. The divide ratio is a 12-bit integer part plus a 12-bit fraction over 4096. The fraction is realised by changing the length of each output period. A cascade of one, two or three accumulators picks each length, so that over many periods the mean ratio is DIVI + DIVF/4096. The spread of the individual period lengths depends on the chosen shaping order.

Software loads the source code, integer divisor, fraction and shaping order while the block is idle, then raises the run enable. The output starts on the first tick of the chosen source. When the enable drops, the period in progress runs to its end. The output then stays low and the busy flag clears.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is held and just after it is released, `clk_out` and `busy` are low.
- R2: The select field is 4 bits. Codes 1..7 select `src_tick[code]`, and one source cycle is one pulse on that bit. Code 0 and codes 8..15 select a constant-low source. With such a code enabled, `busy` is high and `clk_out` never rises. After `run_en` drops, `busy` clears within one cycle.
- R3: With order 0, every output period lasts exactly DIVI source cycles. The fraction has no effect.
- R4: With order 1, a 12-bit accumulator starts at zero and adds DIVF once per period. A period lasts DIVI+1 source cycles when that addition carries out of 12 bits, and DIVI source cycles otherwise.
- R5: With order 2, each period lasts DIVI-1 to DIVI+2 source cycles. With order 3, each period lasts DIVI-3 to DIVI+4 source cycles. No period is ever shorter than 2 source cycles.
- R6: Over the first 4096 periods after enable, the total length is exactly 4096*DIVI + DIVF source cycles for order 1. For orders 2 and 3 the total is within -1..+2 of that value.
- R7: In every period of length L, `clk_out` rises at the period start. It stays high for floor(L/2) source cycles and is low for the rest of the period.
- R8: When `run_en` drops during a period, that period completes at its full length. `busy` clears on the cycle after its last source cycle, and `clk_out` stays low from then on.
- R9: A configuration write (`cfg_we`) is taken only while `busy` is low. A write made while `busy` is high is dropped and does not take effect later.
- R10: All accumulators clear when the block is enabled, so every run with the same settings gives the same sequence of period lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 7 | Source strobes for codes 1..7 (bits [7:1]) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 4 | Source select code |
| cfg_divi | input | 12 | Integer divisor |
| cfg_divf | input | 12 | Fraction numerator over 4096 |
| cfg_order | input | 2 | Noise-shaping order 0..3 |
| run_en | input | 1 | Run enable |
| clk_out | output | 1 | Divided clock, registered |
| busy | output | 1 | High from enable until the output has stopped |

## Verification
The bench builds the block with its default parameters: 12-bit integer and fraction fields and eight source slots. With these defaults, the largest divisor of 4095 and the full 4096-period cycle of the fraction accumulator can be reached. The bench spaces each live source's pulses by its own code number. Because of this, a measured period in system cycles shows both that the right source was selected and how long the period was in source cycles. At the smallest divisors the third-order clamp to 2 is also exercised.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } run_st_e;
endpackage

// File: rtl/fcd_src_pick.sv
module fcd_src_pick #(
    parameter int SRC_N = 8,
    parameter int SEL_W = 4
) (
    input  logic [SRC_N-1:1] src_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    always_comb begin
        tick = 1'b0;
        for (int i = 1; i < SRC_N; i++) begin
            if (sel == SEL_W'(i)) tick = src_tick[i];
        end
    end
endmodule

// File: rtl/fcd_shaper.sv
module fcd_shaper #(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 12,
    localparam int LEN_W = DIV_W + 1
) (
    input  logic [1:0]        order,
    input  logic [DIV_W-1:0]  divi,
    input  logic [FRAC_W-1:0] divf,
    input  logic [FRAC_W-1:0] acc1,
    input  logic [FRAC_W-1:0] acc2,
    input  logic [FRAC_W-1:0] acc3,
    input  logic              c2p,
    input  logic              c3p,
    input  logic              c3pp,
    output logic [LEN_W-1:0]  len,
    output logic [FRAC_W-1:0] acc1_n,
    output logic [FRAC_W-1:0] acc2_n,
    output logic [FRAC_W-1:0] acc3_n,
    output logic              c2p_n,
    output logic              c3p_n,
    output logic              c3pp_n
);
    localparam logic signed [LEN_W:0] MIN_LEN = 2;

    logic [FRAC_W:0]        s1, s2, s3;
    logic signed [3:0]      e1, e2, e2p, e3, e3p, e3pp, dlt;
    logic signed [LEN_W:0]  lsum;

    always_comb begin
        s1   = {1'b0, acc1} + {1'b0, divf};
        s2   = {1'b0, acc2} + {1'b0, s1[FRAC_W-1:0]};
        s3   = {1'b0, acc3} + {1'b0, s2[FRAC_W-1:0]};
        e1   = $signed({3'b000, s1[FRAC_W]});
        e2   = $signed({3'b000, s2[FRAC_W]});
        e3   = $signed({3'b000, s3[FRAC_W]});
        e2p  = $signed({3'b000, c2p});
        e3p  = $signed({3'b000, c3p});
        e3pp = $signed({3'b000, c3pp});
        case (order)
            2'd0:    dlt = 4'sd0;
            2'd1:    dlt = e1;
            2'd2:    dlt = e1 + e2 - e2p;
            default: dlt = e1 + e2 - e2p + e3 - (e3p <<< 1) + e3pp;
        endcase
        lsum = $signed({2'b00, divi}) + $signed({{(LEN_W-3){dlt[3]}}, dlt});
        if (lsum < MIN_LEN) len = LEN_W'(2);
        else                len = lsum[LEN_W-1:0];
        acc1_n = s1[FRAC_W-1:0];
        acc2_n = s2[FRAC_W-1:0];
        acc3_n = s3[FRAC_W-1:0];
        c2p_n  = s2[FRAC_W];
        c3p_n  = s3[FRAC_W];
        c3pp_n = c3p;
    end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
    parameter int SRC_N  = 8,
    parameter int SEL_W  = 4,
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_N-1:1]   src_tick,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_src,
    input  logic [DIV_W-1:0]   cfg_divi,
    input  logic [FRAC_W-1:0]  cfg_divf,
    input  logic [1:0]         cfg_order,
    input  logic               run_en,
    output logic               clk_out,
    output logic               busy
);
    import fcd_pkg::*;
    localparam int LEN_W = DIV_W + 1;

    typedef struct packed {
        run_st_e           st;
        logic [SEL_W-1:0]  sel;
        logic [DIV_W-1:0]  divi;
        logic [FRAC_W-1:0] divf;
        logic [1:0]        order;
        logic [LEN_W-1:0]  pos;
        logic [LEN_W-1:0]  len;
        logic              out;
        logic [FRAC_W-1:0] acc1;
        logic [FRAC_W-1:0] acc2;
        logic [FRAC_W-1:0] acc3;
        logic              c2p;
        logic              c3p;
        logic              c3pp;
    } regs_t;

    regs_t r_q, r_d;
    logic  tick;
    logic [LEN_W-1:0]  sh_len;
    logic [FRAC_W-1:0] sh_a1, sh_a2, sh_a3;
    logic              sh_c2p, sh_c3p, sh_c3pp;

    fcd_src_pick #(.SRC_N(SRC_N), .SEL_W(SEL_W)) u_pick (
        .src_tick (src_tick),
        .sel      (r_q.sel),
        .tick     (tick)
    );

    fcd_shaper #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_shp (
        .order  (r_q.order),
        .divi   (r_q.divi),
        .divf   (r_q.divf),
        .acc1   (r_q.acc1),
        .acc2   (r_q.acc2),
        .acc3   (r_q.acc3),
        .c2p    (r_q.c2p),
        .c3p    (r_q.c3p),
        .c3pp   (r_q.c3pp),
        .len    (sh_len),
        .acc1_n (sh_a1),
        .acc2_n (sh_a2),
        .acc3_n (sh_a3),
        .c2p_n  (sh_c2p),
        .c3p_n  (sh_c3p),
        .c3pp_n (sh_c3pp)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cfg_we) begin
                    r_d.sel   = cfg_src;
                    r_d.divi  = cfg_divi;
                    r_d.divf  = cfg_divf;
                    r_d.order = cfg_order;
                end
                if (run_en) begin
                    r_d.st   = ST_WAIT;
                    r_d.acc1 = '0;
                    r_d.acc2 = '0;
                    r_d.acc3 = '0;
                    r_d.c2p  = 1'b0;
                    r_d.c3p  = 1'b0;
                    r_d.c3pp = 1'b0;
                end
            end
            ST_WAIT: begin
                if (!run_en) begin
                    r_d.st = ST_IDLE;
                end else if (tick) begin
                    r_d.st   = ST_RUN;
                    r_d.pos  = '0;
                    r_d.len  = sh_len;
                    r_d.acc1 = sh_a1;
                    r_d.acc2 = sh_a2;
                    r_d.acc3 = sh_a3;
                    r_d.c2p  = sh_c2p;
                    r_d.c3p  = sh_c3p;
                    r_d.c3pp = sh_c3pp;
                end
            end
            default: begin
                if (tick) begin
                    if (r_q.pos == r_q.len - 1'b1) begin
                        if (run_en) begin
                            r_d.pos  = '0;
                            r_d.len  = sh_len;
                            r_d.acc1 = sh_a1;
                            r_d.acc2 = sh_a2;
                            r_d.acc3 = sh_a3;
                            r_d.c2p  = sh_c2p;
                            r_d.c3p  = sh_c3p;
                            r_d.c3pp = sh_c3pp;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end else begin
                        r_d.pos = r_q.pos + 1'b1;
                    end
                end
            end
        endcase
        r_d.out = (r_d.st == ST_RUN) && (r_d.pos < (r_d.len >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.divi  <= DIV_W'(2);
            r_q.len   <= LEN_W'(2);
        end else begin
            r_q <= r_d;
        end
    end

    assign clk_out = r_q.out;
    assign busy    = (r_q.st != ST_IDLE);
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int SEL_W  = 4,
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 12,
    localparam int LEN_W = DIV_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              busy,
    input logic              clk_out,
    input logic [1:0]        st,
    input logic [LEN_W-1:0]  pos,
    input logic [LEN_W-1:0]  len,
    input logic [SEL_W-1:0]  sel,
    input logic [DIV_W-1:0]  divi,
    input logic [FRAC_W-1:0] divf,
    input logic [1:0]        order
);
    import fcd_pkg::*;

    // R8
    out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !clk_out);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({sel, divi, divf, order}));

    // R5
    len_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (len >= LEN_W'(2)) && (len <= {1'b0, divi} + LEN_W'(4)));

    // R3
    int_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && order == 2'd0 && divi >= DIV_W'(2)) |-> len == {1'b0, divi});

    // R8
    stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(run_en));

    // R7
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> pos == '0);

    // R7
    pos_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> pos < len);
endmodule

bind frac_clk_div fcd_checker #(.SEL_W(SEL_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .busy    (busy),
    .clk_out (clk_out),
    .st      (r_q.st),
    .pos     (r_q.pos),
    .len     (r_q.len),
    .sel     (r_q.sel),
    .divi    (r_q.divi),
    .divf    (r_q.divf),
    .order   (r_q.order)
);

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  sel;
        logic [11:0] divi;
        logic [11:0] divf;
        logic [1:0]  order;
        logic [7:0]  np;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{4'd1, 12'd10,   12'd0,    2'd0, 8'd6},
        '{4'd3, 12'd7,    12'd2000, 2'd0, 8'd6},
        '{4'd1, 12'd4,    12'd1024, 2'd1, 8'd12},
        '{4'd2, 12'd6,    12'd3000, 2'd1, 8'd12},
        '{4'd5, 12'd2,    12'd4095, 2'd1, 8'd12},
        '{4'd1, 12'd9,    12'd1500, 2'd2, 8'd16},
        '{4'd7, 12'd3,    12'd777,  2'd2, 8'd16},
        '{4'd1, 12'd12,   12'd2222, 2'd3, 8'd16},
        '{4'd4, 12'd2,    12'd100,  2'd3, 8'd16},
        '{4'd1, 12'd4095, 12'd4095, 2'd1, 8'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:1]  src_tick;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_src = '0;
    logic [11:0] cfg_divi = '0;
    logic [11:0] cfg_divf = '0;
    logic [1:0]  cfg_order = '0;
    logic        run_en = 1'b0;
    logic        clk_out, busy;

    int nchk = 0;
    int nfail = 0;
    int ph = 0;
    int meas_len [0:63];
    int meas_hi  [0:63];
    int ref_len  [0:63];
    longint meas_sum;

    frac_clk_div u_dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_we(cfg_we),
        .cfg_src(cfg_src), .cfg_divi(cfg_divi), .cfg_divf(cfg_divf),
        .cfg_order(cfg_order), .run_en(run_en), .clk_out(clk_out), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // source code c pulses once every c system cycles
    always @(negedge clk) ph <= ph + 1;
    always_comb begin
        for (int c = 1; c < 8; c++) src_tick[c] = ((ph % c) == 0);
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int sel, input int divi, input int divf, input int order);
        @(negedge clk);
        cfg_src = 4'(sel); cfg_divi = 12'(divi); cfg_divf = 12'(divf); cfg_order = 2'(order);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start_run();
        @(negedge clk);
        run_en = 1'b1;
    endtask

    task automatic stop_run();
        @(negedge clk);
        run_en = 1'b0;
        while (busy) @(negedge clk);
    endtask

    // waits for a rise of clk_out, then measures n periods in source cycles
    task automatic collect(input int n, input int tp);
        bit prev;
        int k, cyc, hi;
        prev = clk_out;
        forever begin
            @(negedge clk);
            if (clk_out && !prev) break;
            prev = clk_out;
        end
        prev = 1'b1; k = 0; cyc = 1; hi = 1; meas_sum = 0;
        while (k < n) begin
            @(negedge clk);
            if (clk_out && !prev) begin
                if (k < 64) begin
                    meas_len[k] = cyc / tp;
                    meas_hi[k]  = hi;
                end
                meas_sum += cyc / tp;
                k++; cyc = 1; hi = 1;
            end else begin
                cyc++;
                if (clk_out) hi++;
            end
            prev = clk_out;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int acc, s, exp_len, lo, hi_b, cnt, di;
        longint base;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(clk_out == 1'b0, "R1 clk_out in reset", clk_out, 0);
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clk_out == 1'b0 && busy == 1'b0, "R1 after reset", {clk_out, busy}, 0);

        // table walk: R2 select, R3 order 0, R4 order 1, R5 bands, R7 duty
        for (int v = 0; v < 10; v++) begin
            cfg_write(VECS[v].sel, VECS[v].divi, VECS[v].divf, VECS[v].order);
            start_run();
            collect(VECS[v].np, VECS[v].sel);
            acc = 0;
            di = VECS[v].divi;
            for (int k = 0; k < VECS[v].np; k++) begin
                s = acc + VECS[v].divf;
                acc = s % 4096;
                case (VECS[v].order)
                    2'd0: chk(meas_len[k] == di, "R3 integer period", meas_len[k], di);
                    2'd1: begin
                        exp_len = di + s / 4096;
                        chk(meas_len[k] == exp_len, "R4 first-order period", meas_len[k], exp_len);
                    end
                    default: begin
                        lo   = (VECS[v].order == 2) ? di - 1 : di - 3;
                        if (lo < 2) lo = 2;
                        hi_b = (VECS[v].order == 2) ? di + 2 : di + 4;
                        chk(meas_len[k] >= lo && meas_len[k] <= hi_b, "R5 period band", meas_len[k], lo);
                    end
                endcase
                chk(meas_hi[k] == (meas_len[k] / 2) * VECS[v].sel, "R7 high time (R2 source spacing)",
                    meas_hi[k], (meas_len[k] / 2) * VECS[v].sel);
            end
            stop_run();
        end

        // R2 ground codes
        foreach (VECS[i]) begin end
        for (int g = 0; g < 3; g++) begin
            int code;
            code = (g == 0) ? 0 : (g == 1) ? 9 : 15;
            cfg_write(code, 4, 0, 0);
            start_run();
            cnt = 0;
            repeat (40) begin
                @(negedge clk);
                if (clk_out) cnt++;
            end
            chk(cnt == 0, "R2 ground select output", cnt, 0);
            chk(busy == 1'b1, "R2 ground select busy", busy, 1);
            run_en = 1'b0;
            @(negedge clk);
            chk(busy == 1'b0, "R2 ground release", busy, 0);
        end

        // R8 disable mid-period
        cfg_write(1, 20, 0, 0);
        start_run();
        while (!clk_out) @(negedge clk);
        cnt = 0;
        repeat (3) begin @(negedge clk); cnt++; end
        run_en = 1'b0;
        while (busy) begin @(negedge clk); cnt++; end
        chk(cnt == 20, "R8 last period completes", cnt, 20);
        s = 0;
        repeat (40) begin
            @(negedge clk);
            if (clk_out || busy) s++;
        end
        chk(s == 0, "R8 output held low after stop", s, 0);

        // R9 writes while busy are dropped
        cfg_write(1, 8, 0, 0);
        start_run();
        collect(2, 1);
        cfg_write(1, 3, 0, 0);
        collect(4, 1);
        for (int k = 0; k < 4; k++) chk(meas_len[k] == 8, "R9 write while busy ignored", meas_len[k], 8);
        stop_run();
        start_run();
        collect(2, 1);
        chk(meas_len[1] == 8, "R9 dropped write not pended", meas_len[1], 8);
        stop_run();
        cfg_write(1, 3, 0, 0);
        start_run();
        collect(2, 1);
        chk(meas_len[1] == 3, "R9 write while idle taken", meas_len[1], 3);
        stop_run();

        // R10 reproducible dither after re-enable
        cfg_write(1, 6, 1234, 2);
        start_run();
        collect(16, 1);
        for (int k = 0; k < 16; k++) ref_len[k] = meas_len[k];
        stop_run();
        start_run();
        collect(16, 1);
        for (int k = 0; k < 16; k++) chk(meas_len[k] == ref_len[k], "R10 repeat sequence", meas_len[k], ref_len[k]);
        stop_run();

        // R6 averages over a full fraction cycle
        cfg_write(1, 2, 1000, 1);
        start_run();
        collect(4096, 1);
        chk(meas_sum == 4096 * 2 + 1000, "R6 order1 total", meas_sum, 4096 * 2 + 1000);
        stop_run();

        cfg_write(1, 3, 2500, 2);
        start_run();
        collect(4096, 1);
        base = 4096 * 3 + 2500;
        chk(meas_sum >= base - 1 && meas_sum <= base + 2, "R6 order2 total", meas_sum, base);
        stop_run();

        cfg_write(1, 5, 333, 3);
        start_run();
        collect(4096, 1);
        base = 4096 * 5 + 333;
        chk(meas_sum >= base - 1 && meas_sum <= base + 2, "R6 order3 total", meas_sum, base);
        stop_run();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule